// File: doc/BRIEF.md
# Up/Down Periodic Timer with Prescaler

A general-purpose timer/counter of configurable width (16 bits by default, 32 also supported). Software controls it through a small 32-bit register bus. There are four locations: a reload value, the live count (read only), a control word, and an acknowledge location where a write of any value drops the pending interrupt. The counter steps once per prescaled tick. An external source-clock enable `src_tick` feeds the prescaler, which divides it by 1, 16, 256 or 32768.

The counter counts either up or down. In free-running mode it wraps across the full range of the counter. In periodic mode it restarts from the reload value. Each time a step lands on the terminal value, the block sets a sticky interrupt: zero when counting down, all-ones when counting up. The time between interrupts in periodic down mode is (reload + 1) × divide source ticks. Everything runs in the core clock domain.

Top module: `updn_timer`

## Requirements
- R1: After reset the reload value, the count, the control word and `irq` are all zero, and nothing steps until the timer is started.
- R2: A write to the control location (address 2) with bit 7 set starts the timer and sets the count in the same clock edge. The count takes the reload value in periodic mode (bit 6 = 1). In free-running mode it takes all-ones when counting down (bit 5 = 0) and zero when counting up (bit 5 = 1). The same write also restarts the prescaler.
- R3: When counting down, each step lowers the count by one. A step taken at zero wraps to all-ones in free-running mode and to the reload value in periodic mode.
- R4: When counting up, each step raises the count by one. A step taken at all-ones wraps to zero in free-running mode and to the reload value in periodic mode.
- R5: Control bits 3:2 select how many `src_tick` pulses make one step: 00 = 1, 01 = 16, 10 = 256, 11 = 32768.
- R6: A step whose result equals the terminal value (zero when counting down, all-ones when counting up) sets `irq` on the same edge. `irq` then stays high until it is acknowledged.
- R7: A write of any data to address 3 clears `irq` on the next edge. If a terminal step happens in the same cycle, `irq` stays high.
- R8: A write to the reload location (address 0) while the timer runs leaves the live count untouched. The new value is used from the next reload on.
- R9: A control write with bit 7 clear stops the timer. It leaves the count unchanged, and the count holds while the timer is stopped.
- R10: `rd_data` returns, with no delay, the following for `rd_addr`: 0 gives the reload value, 1 gives the live count, 2 gives the control bits 7, 6, 5 and 3:2 in their positions with all other bits zero, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One-cycle enable marking a source-clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky terminal-count interrupt |

## Verification
The assertions assume that the bus inputs and `src_tick` are known and stable around every rising clock edge. They also assume that only one register location is written per cycle, so a reload write and a control write never coincide. The stimulus changes every input only on the falling edge and draws addresses, data and tick density from a seeded generator. Control words are weighted toward the short prescaler settings so that steps and wraps happen often. Separate directed phases cover the long divide and the full-range free-running wraps.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ACK   = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RUN      = 7;
  localparam int unsigned BIT_PERIODIC = 6;
  localparam int unsigned BIT_UP       = 5;
  localparam int unsigned BIT_PSEL_LO  = 2;

  // prescaler: log2 of the divide for settings 01 and 10; 11 uses the full width
  localparam int unsigned PRE_W     = 15;
  localparam int unsigned PSEL1_LOG = 4;
  localparam int unsigned PSEL2_LOG = 8;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       count_up;
    logic [1:0] psel;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [31:0] d);
    ctrl_t c;
    c.run      = d[BIT_RUN];
    c.periodic = d[BIT_PERIODIC];
    c.count_up = d[BIT_UP];
    c.psel     = d[BIT_PSEL_LO +: 2];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctrl(input ctrl_t c);
    logic [31:0] d;
    d                   = '0;
    d[BIT_RUN]          = c.run;
    d[BIT_PERIODIC]     = c.periodic;
    d[BIT_UP]           = c.count_up;
    d[BIT_PSEL_LO +: 2] = c.psel;
    return d;
  endfunction

endpackage

// File: rtl/updn_timer_prescale.sv
module updn_timer_prescale
  import updn_timer_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       src_tick,
  input  logic [1:0] psel,
  output logic       step
);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pcnt_d;
  logic [PW-1:0] limit;

  // terminal prescaler count for each divide setting
  always_comb begin
    unique case (psel)
      2'd0:    limit = '0;
      2'd1:    limit = PW'((1 << PSEL1_LOG) - 1);
      2'd2:    limit = PW'((1 << PSEL2_LOG) - 1);
      default: limit = '1;
    endcase
  end

  assign step = run & ~restart & src_tick & (pcnt_q == limit);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart || !run) begin
      pcnt_d = '0;
    end else if (src_tick) begin
      pcnt_d = (pcnt_q == limit) ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/updn_timer_counter.sv
module updn_timer_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic         periodic,
  input  logic         count_up,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         term_hit
);

  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] wrap_val;
  logic [W-1:0] stepped;
  logic [W-1:0] terminal;
  logic         at_end;

  always_comb begin
    terminal = count_up ? FULL : ZERO;
    wrap_val = periodic ? load_val : (count_up ? ZERO : FULL);
    at_end   = (cnt_q == terminal);
    if (at_end) begin
      stepped = wrap_val;
    end else if (count_up) begin
      stepped = cnt_q + 1'b1;
    end else begin
      stepped = cnt_q - 1'b1;
    end
  end

  always_comb begin
    cnt_d    = cnt_q;
    term_hit = 1'b0;
    if (start) begin
      cnt_d = wrap_val;
    end else if (step) begin
      cnt_d    = stepped;
      term_hit = (stepped == terminal);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);

  ctrl_t              ctrl_q;
  ctrl_t              ctrl_d;
  ctrl_t              ctrl_eff;
  logic [CNT_W-1:0]   load_q;
  logic [CNT_W-1:0]   load_d;
  logic               irq_q;
  logic               irq_d;
  logic               ctrl_wr;
  logic               load_wr;
  logic               ack_wr;
  logic               start;
  logic               step;
  logic               term_hit;
  logic [CNT_W-1:0]   cnt_val;

  assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
  assign load_wr = wr_en && (wr_addr == SEL_LOAD);
  assign ack_wr  = wr_en && (wr_addr == SEL_ACK);
  assign start   = ctrl_wr && wr_data[BIT_RUN];

  // on a control write the counter sees the new mode at once
  assign ctrl_eff = ctrl_wr ? unpack_ctrl(wr_data) : ctrl_q;

  always_comb begin
    ctrl_d = ctrl_wr ? unpack_ctrl(wr_data) : ctrl_q;
    load_d = load_wr ? wr_data[CNT_W-1:0] : load_q;
    irq_d  = term_hit | (irq_q & ~ack_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      irq_q  <= irq_d;
    end
  end

  updn_timer_prescale #(
    .PW(PRE_W)
  ) u_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .restart  (ctrl_wr),
    .src_tick (src_tick),
    .psel     (ctrl_q.psel),
    .step     (step)
  );

  updn_timer_counter #(
    .W(CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .step     (step),
    .periodic (ctrl_eff.periodic),
    .count_up (ctrl_eff.count_up),
    .load_val (load_q),
    .cnt      (cnt_val),
    .term_hit (term_hit)
  );

  always_comb begin
    unique case (rd_addr)
      SEL_LOAD:  rd_data = 32'(load_q);
      SEL_VALUE: rd_data = 32'(cnt_val);
      SEL_CTRL:  rd_data = pack_ctrl(ctrl_q);
      default:   rd_data = '0;
    endcase
  end

  assign irq = irq_q;

endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk
  import updn_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [31:0]  wr_data,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic [W-1:0] load_val,
  input logic         run,
  input logic         up,
  input logic         step,
  input logic         term_hit
);

  // R6
  term_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> irq);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == SEL_ACK)) |=> irq);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(term_hit));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_ACK && !term_hit) |=> !irq);

  // R2
  start_periodic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_CTRL && wr_data[BIT_RUN] && wr_data[BIT_PERIODIC])
      |=> (cnt == $past(load_val)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && wr_addr == SEL_CTRL)) |=> $stable(cnt));

  // R8
  load_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_LOAD && !step) |=> $stable(cnt));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up && cnt != '0 && !(wr_en && wr_addr == SEL_CTRL))
      |=> (cnt == W'($past(cnt) - 1'b1)));

endmodule

bind updn_timer updn_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .irq      (irq),
  .cnt      (cnt_val),
  .load_val (load_q),
  .run      (ctrl_q.run),
  .up       (ctrl_q.count_up),
  .step     (step),
  .term_hit (term_hit)
);

// File: tb/updn_timer_bench.sv
`timescale 1ns/1ps
module updn_timer_bench;

  localparam int unsigned W = 16;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic        clk;
  logic        rst_n;
  logic        src_tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;

  int compared;
  int mismatched;
  bit done;

  // reference state
  logic [W-1:0] m_load, m_cnt;
  logic         m_irq, m_run, m_per, m_up;
  logic [1:0]   m_psel;
  int unsigned  m_pcnt;

  updn_timer #(.CNT_W(W)) u_updn_timer (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int unsigned div_of(input logic [1:0] p);
    case (p)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 256;
      default: return 32768;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return 32'(m_load);
      2'd1:    return 32'(m_cnt);
      2'd2:    return {24'd0, m_run, m_per, m_up, 1'b0, m_psel, 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic         stp;
    logic         term;
    logic [W-1:0] nx;
    if (!rst_n) begin
      m_load = '0; m_cnt = '0; m_irq = 1'b0; m_run = 1'b0;
      m_per = 1'b0; m_up = 1'b0; m_psel = 2'd0; m_pcnt = 0;
    end else begin
      stp  = 1'b0;
      term = 1'b0;
      if (wr_en && wr_addr == 2'd2) begin
        m_run = wr_data[7]; m_per = wr_data[6]; m_up = wr_data[5];
        m_psel = wr_data[3:2]; m_pcnt = 0;
        if (wr_data[7]) m_cnt = m_per ? m_load : (m_up ? '0 : MAXV);
      end else if (m_run && src_tick) begin
        if (m_pcnt == div_of(m_psel) - 1) begin
          m_pcnt = 0;
          stp = 1'b1;
        end else begin
          m_pcnt = m_pcnt + 1;
        end
      end
      if (stp) begin
        if (m_up) begin
          nx = (m_cnt == MAXV) ? (m_per ? m_load : '0) : m_cnt + 1'b1;
          term = (nx == MAXV);
        end else begin
          nx = (m_cnt == '0) ? (m_per ? m_load : MAXV) : m_cnt - 1'b1;
          term = (nx == '0);
        end
        m_cnt = nx;
      end
      if (wr_en && wr_addr == 2'd0) m_load = wr_data[W-1:0];
      m_irq = term | (m_irq & ~(wr_en && wr_addr == 2'd3));
    end
  end

  task automatic check(input string tag);
    logic [31:0] e;
    e = exp_read(rd_addr);
    compared++;
    if (rd_data !== e) begin
      mismatched++;
      $display("FAIL %s rd_addr=%0d rd_data=%h expected=%h", tag, rd_addr, rd_data, e);
    end
    compared++;
    if (irq !== m_irq) begin
      mismatched++;
      $display("FAIL %s irq=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                     input logic [1:0] ra, input logic st, input string tag);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; src_tick = st;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input logic st, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0, 2'd1, st, tag);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h1357_2468));
    compared = 0; mismatched = 0; done = 1'b0;
    rst_n = 1'b0; src_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, ticks do nothing while stopped
    for (int a = 0; a < 4; a++) cyc(1'b0, 2'd0, 32'd0, 2'(a), 1'b1, "R1");

    // R2, R3: periodic down from 5
    cyc(1'b1, 2'd0, 32'd5, 2'd0, 1'b0, "R10");
    cyc(1'b1, 2'd2, 32'h0000_00C0, 2'd1, 1'b0, "R2");
    idle(14, 1'b1, "R3");
    cyc(1'b0, 2'd0, 32'd0, 2'd2, 1'b0, "R10");
    // R7: acknowledge with no step pending
    cyc(1'b1, 2'd3, 32'hDEAD_BEEF, 2'd3, 1'b0, "R7");
    if (irq !== 1'b0) begin mismatched++; $display("FAIL R7 irq=%b expected=0", irq); end
    compared++;

    // R4: periodic up near the top, then R6 via terminal hits
    cyc(1'b1, 2'd0, 32'h0000_FFFC, 2'd0, 1'b0, "R8");
    cyc(1'b1, 2'd2, 32'h0000_00E0, 2'd1, 1'b0, "R2");
    idle(12, 1'b1, "R4");
    idle(5, 1'b0, "R6");

    // R5: divide 16 and 256 with sparse ticks
    cyc(1'b1, 2'd0, 32'd40, 2'd0, 1'b0, "R8");
    cyc(1'b1, 2'd2, 32'h0000_00C4, 2'd1, 1'b0, "R5");
    for (int i = 0; i < 300; i++) cyc(1'b0, 2'd0, 32'd0, 2'd1, 1'($urandom % 2), "R5");
    cyc(1'b1, 2'd2, 32'h0000_00E8, 2'd1, 1'b0, "R5");
    idle(700, 1'b1, "R5");

    // R7: acknowledge coincides with a terminal step (reload 0, down, divide 1)
    cyc(1'b1, 2'd0, 32'd0, 2'd0, 1'b0, "R8");
    cyc(1'b1, 2'd2, 32'h0000_00C0, 2'd1, 1'b0, "R2");
    idle(2, 1'b1, "R6");
    cyc(1'b1, 2'd3, 32'd0, 2'd1, 1'b1, "R7");
    if (irq !== 1'b1) begin mismatched++; $display("FAIL R7 irq=%b expected=1", irq); end
    compared++;

    // R8: reload written while running takes effect at wrap only
    cyc(1'b1, 2'd0, 32'd3, 2'd0, 1'b0, "R8");
    cyc(1'b1, 2'd2, 32'h0000_00C0, 2'd1, 1'b0, "R2");
    idle(2, 1'b1, "R8");
    cyc(1'b1, 2'd0, 32'd9, 2'd1, 1'b0, "R8");
    idle(15, 1'b1, "R8");

    // R9: stop holds the count
    cyc(1'b1, 2'd2, 32'h0000_0040, 2'd1, 1'b1, "R9");
    idle(20, 1'b1, "R9");

    // R5: divide 32768, free down from all-ones
    cyc(1'b1, 2'd2, 32'h0000_008C, 2'd1, 1'b0, "R5");
    idle(32770, 1'b1, "R5");

    // R3: free-running down through the full range and wrap
    cyc(1'b1, 2'd2, 32'h0000_0080, 2'd1, 1'b0, "R3");
    idle(65540, 1'b1, "R3");
    cyc(1'b1, 2'd3, 32'd1, 2'd1, 1'b0, "R7");

    // R4: free-running up through the full range and wrap
    cyc(1'b1, 2'd2, 32'h0000_00A0, 2'd1, 1'b0, "R4");
    idle(65540, 1'b1, "R4");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic        we;
      logic [1:0]  wa;
      logic [31:0] wd;
      we = ($urandom % 4) == 0;
      wa = 2'($urandom % 4);
      wd = $urandom;
      if (wa == 2'd0) wd = $urandom % 64;
      if (wa == 2'd2) begin
        wd = '0;
        wd[7] = ($urandom % 4) != 0;
        wd[6] = $urandom % 2;
        wd[5] = $urandom % 2;
        wd[3:2] = (($urandom % 8) < 6) ? 2'd0 : 2'd1;
      end
      cyc(we, wa, wd, 2'($urandom % 4), ($urandom % 4) != 0, "R10");
    end

    report();
  end

endmodule